// File: doc/BRIEF.md
# Instruction Cycle Sequencer

This block is the control state machine of a small accumulator machine. It steps every instruction through its subcycles: a fetch, an indirect operand-address read when the instruction asks for one, an execute step, and an interrupt entry when a request is pending and interrupts are enabled. It owns the program counter, the memory address and memory buffer registers, the instruction register, an accumulator, a stack pointer and an interrupt-enable flag, and it moves data between them one register transfer per clock.

Memory is a single-port synchronous array reached through an address bus, a read strobe, a write strobe and separate data buses. The memory address bus always shows the memory address register and the write data bus always shows the memory buffer register. The memory interface has fixed timing and no back-pressure: a read strobe in one cycle returns data on `mem_rdata` in the next cycle, and a write completes at the edge that ends the strobe cycle. Instruction words are 16 bits: bits 15:12 hold the opcode, bit 11 is the indirect flag and bits 10:0 hold an address.

Opcodes: 1 load, 2 store, 3 add, 4 jump, 5 enable interrupts, 6 return from interrupt; 0 and every other value do nothing. The execute step stands in for a full datapath and only covers these operations.

Top module: `icyc_sequencer`

## Requirements
- R1: A fetch loads MAR from PC, pulses `mem_rd` once, captures the returned word in MBR and then copies MBR into IR, so `ir_o` holds the word stored at the instruction's address.
- R2: PC advances by exactly one at the end of each fetch, unless execute later loads it (jump, return).
- R3: For opcodes 1 to 4 with bit 11 set, one extra read at address bits 10:0 takes place before execute, and bits 10:0 of the word read become the effective address; for any other opcode bit 11 is ignored. Read counts per instruction: load and add 2 (3 indirect), store and jump 1 (2 indirect), no-op and enable 1, return 2.
- R4: Execute: load sets the accumulator to mem[EA]; add sets it to accumulator plus mem[EA] modulo 2^16; store writes the accumulator to mem[EA]; jump sets PC to EA; enable sets the interrupt-enable flag.
- R5: After execute, when `irq` is 1 and interrupt enable is 1, the block writes PC (the address of the next instruction) to the memory word at the stack pointer.
- R6: In the cycle after that write, PC equals the handler address (default 0x200), interrupt enable is 0 and the stack pointer is one less than before.
- R7: While interrupt enable is 0, `irq` has no effect: no stack write, the stack pointer and PC follow the program.
- R8: Return from interrupt increments the stack pointer, reads the word at the new stack pointer into PC and sets interrupt enable.
- R9: Reset (active-low `rst_n`) gives PC 0, accumulator 0, interrupt enable 0, stack pointer at the stack top (default 0x7FF), and no read or write strobe.
- R10: `mem_rd` and `mem_wr` are never high in the same cycle, and during a stack push `mem_addr` is the stack pointer and `mem_wdata` carries PC.
- R11: `instr_done` is high for exactly one cycle after each instruction's execute step, before any interrupt entry, with that instruction's results already visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq | input | 1 | Level interrupt request |
| mem_addr | output | 11 | Memory address (MAR) |
| mem_rd | output | 1 | Read strobe, data returns next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data (MBR) |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_rd` |
| pc_o | output | 11 | Program counter |
| ir_o | output | 16 | Instruction register |
| acc_o | output | 16 | Accumulator |
| sp_o | output | 11 | Stack pointer |
| ie_o | output | 1 | Interrupt enable flag |
| instr_done | output | 1 | One-cycle pulse at the end of each instruction |

## Verification
A state machine that skips or repeats a subcycle shows up in the number of read strobes between two `instr_done` pulses, which the bench counts for every instruction. A missed indirect step, or one that was not needed, shows up in the accumulator or PC at the very next pulse. A wrong interrupt decision shows up within two cycles of the pulse as a stack write that should not occur, or one that is missing, and a wrong vector or flag shows up in the cycle right after the push.

// File: rtl/icyc_pkg.sv
package icyc_pkg;

  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OPC_LOAD  = 4'd1;
  localparam logic [OP_W-1:0] OPC_STORE = 4'd2;
  localparam logic [OP_W-1:0] OPC_ADD   = 4'd3;
  localparam logic [OP_W-1:0] OPC_JUMP  = 4'd4;
  localparam logic [OP_W-1:0] OPC_ENINT = 4'd5;
  localparam logic [OP_W-1:0] OPC_RETI  = 4'd6;

  typedef enum logic [3:0] {
    S_F_ADDR, S_F_RD, S_F_CAP, S_F_IR,
    S_I_ADDR, S_I_RD, S_I_CAP,
    S_E_ADDR, S_E_RD, S_E_CAP, S_E_ST, S_E_WR,
    S_DONE, S_T_SAVE, S_T_WR
  } cyc_state_e;

  typedef enum logic [2:0] {MAR_KEEP, MAR_PC, MAR_FIELD, MAR_SP, MAR_SP_UP} mar_src_e;
  typedef enum logic [1:0] {MBR_KEEP, MBR_MEM, MBR_PC, MBR_ACC} mbr_src_e;
  typedef enum logic [1:0] {ACC_KEEP, ACC_MEM, ACC_SUM} acc_src_e;
  typedef enum logic [2:0] {PC_KEEP, PC_STEP, PC_FIELD, PC_MEM, PC_VEC} pc_src_e;

  typedef struct packed {
    mar_src_e mar;
    mbr_src_e mbr;
    acc_src_e acc;
    pc_src_e  pc;
    logic     ir_ld;
    logic     sp_up;
    logic     sp_down;
    logic     ie_set;
    logic     ie_clr;
    logic     rd;
    logic     wr;
  } xfer_ctrl_t;

  localparam xfer_ctrl_t CTRL_IDLE = '{
    mar: MAR_KEEP, mbr: MBR_KEEP, acc: ACC_KEEP, pc: PC_KEEP,
    ir_ld: 1'b0, sp_up: 1'b0, sp_down: 1'b0, ie_set: 1'b0,
    ie_clr: 1'b0, rd: 1'b0, wr: 1'b0
  };

  function automatic logic takes_operand(input logic [OP_W-1:0] op);
    return (op == OPC_LOAD) || (op == OPC_STORE) ||
           (op == OPC_ADD)  || (op == OPC_JUMP);
  endfunction

endpackage

// File: rtl/icyc_ctrl_fsm.sv
module icyc_ctrl_fsm
  import icyc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq,
  input  logic             ie,
  input  logic [OP_W-1:0]  mbr_op,
  input  logic             mbr_ind,
  input  logic [OP_W-1:0]  ir_op,
  output cyc_state_e       state,
  output xfer_ctrl_t       ctrl
);

  cyc_state_e state_q, state_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_F_ADDR;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    ctrl    = CTRL_IDLE;
    case (state_q)
      S_F_ADDR: begin ctrl.mar = MAR_PC;  state_d = S_F_RD;  end
      S_F_RD:   begin ctrl.rd  = 1'b1;    state_d = S_F_CAP; end
      S_F_CAP:  begin ctrl.mbr = MBR_MEM; state_d = S_F_IR;  end
      S_F_IR: begin
        ctrl.ir_ld = 1'b1;
        ctrl.pc    = PC_STEP;
        state_d    = (mbr_ind && takes_operand(mbr_op)) ? S_I_ADDR : S_E_ADDR;
      end
      S_I_ADDR: begin ctrl.mar = MAR_FIELD; state_d = S_I_RD;   end
      S_I_RD:   begin ctrl.rd  = 1'b1;      state_d = S_I_CAP;  end
      S_I_CAP:  begin ctrl.mbr = MBR_MEM;   state_d = S_E_ADDR; end
      S_E_ADDR: begin
        case (ir_op)
          OPC_LOAD, OPC_ADD: begin ctrl.mar = MAR_FIELD; state_d = S_E_RD; end
          OPC_STORE:         begin ctrl.mar = MAR_FIELD; state_d = S_E_ST; end
          OPC_JUMP:          begin ctrl.pc = PC_FIELD;   state_d = S_DONE; end
          OPC_ENINT:         begin ctrl.ie_set = 1'b1;   state_d = S_DONE; end
          OPC_RETI: begin
            ctrl.mar   = MAR_SP_UP;
            ctrl.sp_up = 1'b1;
            state_d    = S_E_RD;
          end
          default: state_d = S_DONE;
        endcase
      end
      S_E_RD: begin ctrl.rd = 1'b1; state_d = S_E_CAP; end
      S_E_CAP: begin
        if (ir_op == OPC_LOAD) ctrl.acc = ACC_MEM;
        if (ir_op == OPC_ADD)  ctrl.acc = ACC_SUM;
        if (ir_op == OPC_RETI) begin
          ctrl.pc     = PC_MEM;
          ctrl.ie_set = 1'b1;
        end
        state_d = S_DONE;
      end
      S_E_ST: begin ctrl.mbr = MBR_ACC; state_d = S_E_WR; end
      S_E_WR: begin ctrl.wr  = 1'b1;    state_d = S_DONE; end
      S_DONE: state_d = (irq && ie) ? S_T_SAVE : S_F_ADDR;
      S_T_SAVE: begin
        ctrl.mbr = MBR_PC;
        ctrl.mar = MAR_SP;
        state_d  = S_T_WR;
      end
      S_T_WR: begin
        ctrl.wr      = 1'b1;
        ctrl.pc      = PC_VEC;
        ctrl.sp_down = 1'b1;
        ctrl.ie_clr  = 1'b1;
        state_d      = S_F_ADDR;
      end
      default: state_d = S_F_ADDR;
    endcase
  end

  assign state = state_q;

  AST_INT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_T_SAVE) |-> $past(ie && irq)); // R7

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DONE) |=> (state_q != S_DONE)); // R11

endmodule

// File: rtl/icyc_xfer_regs.sv
module icyc_xfer_regs
  import icyc_pkg::*;
#(
  parameter int          DATA_W     = 16,
  parameter int          ADDR_W     = 11,
  parameter int unsigned STACK_TOP  = 2047,
  parameter int unsigned HANDLER_AT = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  xfer_ctrl_t        ctrl,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mbr,
  output logic [DATA_W-1:0] ir,
  output logic [DATA_W-1:0] acc,
  output logic [ADDR_W-1:0] sp,
  output logic              ie
);

  localparam logic [ADDR_W-1:0] SP_INIT = ADDR_W'(STACK_TOP);
  localparam logic [ADDR_W-1:0] VEC_PC  = ADDR_W'(HANDLER_AT);
  localparam int                PAD_W   = DATA_W - ADDR_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc  <= '0;
      mar <= '0;
      mbr <= '0;
      ir  <= '0;
      acc <= '0;
      sp  <= SP_INIT;
      ie  <= 1'b0;
    end else begin
      case (ctrl.mar)
        MAR_PC:    mar <= pc;
        MAR_FIELD: mar <= mbr[ADDR_W-1:0];
        MAR_SP:    mar <= sp;
        MAR_SP_UP: mar <= sp + 1'b1;
        default:   ;
      endcase
      case (ctrl.mbr)
        MBR_MEM: mbr <= mem_rdata;
        MBR_PC:  mbr <= {{PAD_W{1'b0}}, pc};
        MBR_ACC: mbr <= acc;
        default: ;
      endcase
      case (ctrl.acc)
        ACC_MEM: acc <= mem_rdata;
        ACC_SUM: acc <= acc + mem_rdata;
        default: ;
      endcase
      case (ctrl.pc)
        PC_STEP:  pc <= pc + 1'b1;
        PC_FIELD: pc <= mbr[ADDR_W-1:0];
        PC_MEM:   pc <= mem_rdata[ADDR_W-1:0];
        PC_VEC:   pc <= VEC_PC;
        default:  ;
      endcase
      if (ctrl.ir_ld)   ir <= mbr;
      if (ctrl.sp_up)   sp <= sp + 1'b1;
      if (ctrl.sp_down) sp <= sp - 1'b1;
      if (ctrl.ie_set)  ie <= 1'b1;
      if (ctrl.ie_clr)  ie <= 1'b0;
    end
  end

endmodule

// File: rtl/icyc_sequencer.sv
module icyc_sequencer
  import icyc_pkg::*;
#(
  parameter int          DATA_W     = 16,
  parameter int unsigned STACK_TOP  = 2047,
  parameter int unsigned HANDLER_AT = 512
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      irq,
  output logic [DATA_W-OP_W-2:0]    mem_addr,
  output logic                      mem_rd,
  output logic                      mem_wr,
  output logic [DATA_W-1:0]         mem_wdata,
  input  logic [DATA_W-1:0]         mem_rdata,
  output logic [DATA_W-OP_W-2:0]    pc_o,
  output logic [DATA_W-1:0]         ir_o,
  output logic [DATA_W-1:0]         acc_o,
  output logic [DATA_W-OP_W-2:0]    sp_o,
  output logic                      ie_o,
  output logic                      instr_done
);

  localparam int ADDR_W  = DATA_W - OP_W - 1;
  localparam int IND_BIT = ADDR_W;

  cyc_state_e        state;
  xfer_ctrl_t        ctrl;
  logic [ADDR_W-1:0] pc, mar, sp;
  logic [DATA_W-1:0] mbr, ir, acc;
  logic              ie;

  icyc_ctrl_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq     (irq),
    .ie      (ie),
    .mbr_op  (mbr[DATA_W-1 -: OP_W]),
    .mbr_ind (mbr[IND_BIT]),
    .ir_op   (ir[DATA_W-1 -: OP_W]),
    .state   (state),
    .ctrl    (ctrl)
  );

  icyc_xfer_regs #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .STACK_TOP  (STACK_TOP),
    .HANDLER_AT (HANDLER_AT)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl),
    .mem_rdata (mem_rdata),
    .pc        (pc),
    .mar       (mar),
    .mbr       (mbr),
    .ir        (ir),
    .acc       (acc),
    .sp        (sp),
    .ie        (ie)
  );

  assign mem_addr   = mar;
  assign mem_wdata  = mbr;
  assign mem_rd     = ctrl.rd;
  assign mem_wr     = ctrl.wr;
  assign pc_o       = pc;
  assign ir_o       = ir;
  assign acc_o      = acc;
  assign sp_o       = sp;
  assign ie_o       = ie;
  assign instr_done = (state == S_DONE);

  AST_IR_FROM_MBR: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_F_IR) |=> (ir == $past(mbr))); // R1

  AST_FETCH_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_F_IR) |=> (pc == $past(pc) + 1'b1)); // R2

  AST_INDIRECT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_I_ADDR) |-> (ir[IND_BIT] && takes_operand(ir[DATA_W-1 -: OP_W]))); // R3

  AST_PUSH_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_T_WR) |-> (mem_wr && mem_addr == sp && mem_wdata[ADDR_W-1:0] == pc)); // R5

  AST_VECTOR_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_T_WR) |=> (pc == ADDR_W'(HANDLER_AT) && !ie && sp == $past(sp) - 1'b1)); // R6

  AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R10

endmodule

// File: tb/icyc_sequencer_test.sv
`timescale 1ns/1ps
module icyc_sequencer_test;

  localparam int LIMIT = 20000;

  typedef struct packed {
    logic [15:0] ir;
    logic [15:0] acc;
    logic [10:0] pc;
    logic [3:0]  reads;
    logic        ie;
  } vec_t;

  // Program at 0: load 100; add 101; load @102; store 110; add @104;
  // jump 8; (8) store @105; (9) no-op with bit 11 set; (10) enable.
  localparam vec_t VEC [9] = '{
    '{16'h1064, 16'h0005, 11'd1,  4'd2, 1'b0},
    '{16'h3065, 16'h000C, 11'd2,  4'd2, 1'b0},
    '{16'h1866, 16'h0042, 11'd3,  4'd3, 1'b0},
    '{16'h206E, 16'h0042, 11'd4,  4'd1, 1'b0},
    '{16'h3868, 16'h0049, 11'd5,  4'd3, 1'b0},
    '{16'h4008, 16'h0049, 11'd8,  4'd1, 1'b0},
    '{16'h2869, 16'h0049, 11'd9,  4'd2, 1'b0},
    '{16'h0864, 16'h0049, 11'd10, 4'd1, 1'b0},
    '{16'h5000, 16'h0049, 11'd11, 4'd1, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq = 1'b0;
  logic [10:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic [10:0] pc_o, sp_o;
  logic [15:0] ir_o, acc_o;
  logic        ie_o, instr_done;

  logic [15:0] mem [0:2047];
  int n_checks = 0;
  int n_fails  = 0;
  int rd_count = 0;
  int cycles   = 0;

  always #2.5 clk = ~clk;

  icyc_sequencer uut (
    .clk(clk), .rst_n(rst_n), .irq(irq),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .pc_o(pc_o), .ir_o(ir_o), .acc_o(acc_o), .sp_o(sp_o),
    .ie_o(ie_o), .instr_done(instr_done)
  );

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) mem[mem_addr] <= mem_wdata;
  end

  always @(negedge clk) if (rst_n && mem_rd) rd_count++;

  always @(posedge clk) begin
    cycles++;
    if (cycles == LIMIT) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog (all) actual=timeout expected=finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!instr_done);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = 16'h0000;
    mem[0] = 16'h1064; mem[1] = 16'h3065; mem[2] = 16'h1866;
    mem[3] = 16'h206E; mem[4] = 16'h3868; mem[5] = 16'h4008;
    mem[6] = 16'h1FFF; mem[7] = 16'h1FFF;
    mem[8] = 16'h2869; mem[9] = 16'h0864; mem[10] = 16'h5000;
    mem[11] = 16'h1065;
    mem[100] = 16'h0005; mem[101] = 16'h0007; mem[102] = 16'h0067;
    mem[103] = 16'h0042; mem[104] = 16'h0065; mem[105] = 16'h006F;
    mem[11'h200] = 16'h6000;

    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 pc", 32'(pc_o), 32'h0);
    chk("R9 acc", 32'(acc_o), 32'h0);
    chk("R9 ie", 32'(ie_o), 32'h0);
    chk("R9 sp", 32'(sp_o), 32'h7FF);
    chk("R9 strobes", 32'({mem_rd, mem_wr}), 32'h0);

    irq   = 1'b1;   // held through the table: ignored while disabled (R7)
    rst_n = 1'b1;

    foreach (VEC[i]) begin
      wait_done();
      chk("R1 ir", 32'(ir_o), 32'(VEC[i].ir));
      chk("R2 pc", 32'(pc_o), 32'(VEC[i].pc));
      chk("R3 reads", rd_count, 32'(VEC[i].reads));
      chk("R4 acc", 32'(acc_o), 32'(VEC[i].acc));
      chk("R4 ie", 32'(ie_o), 32'(VEC[i].ie));
      chk("R7 sp", 32'(sp_o), 32'h7FF);
      chk("R7 stack", 32'(mem[11'h7FF]), 32'h0);
      rd_count = 0;
      @(negedge clk);
      chk("R11 pulse width", 32'(instr_done), 32'h0);
      if (mem_rd) rd_count++;
    end

    // R5, R10: interrupt push after the enable instruction
    do @(negedge clk); while (!mem_wr);
    chk("R10 push addr", 32'(mem_addr), 32'h7FF);
    chk("R5 push data", 32'(mem_wdata), 32'd11);
    chk("R10 no read", 32'(mem_rd), 32'h0);
    irq = 1'b0;
    @(negedge clk);
    chk("R6 vector", 32'(pc_o), 32'h200);
    chk("R6 ie cleared", 32'(ie_o), 32'h0);
    chk("R6 sp down", 32'(sp_o), 32'h7FE);
    chk("R5 stack word", 32'(mem[11'h7FF]), 32'd11);

    // R8: return from interrupt
    wait_done();
    chk("R8 pc", 32'(pc_o), 32'd11);
    chk("R8 ie", 32'(ie_o), 32'h1);
    chk("R8 sp", 32'(sp_o), 32'h7FF);
    chk("R3 reads reti", rd_count, 32'd2);
    rd_count = 0;

    wait_done();
    chk("R4 load after return", 32'(acc_o), 32'd7);
    chk("R2 pc after return", 32'(pc_o), 32'd12);
    chk("R4 store direct", 32'(mem[110]), 32'h0042);
    chk("R4 store indirect", 32'(mem[111]), 32'h0049);
    chk("R4 jump skipped words", 32'(mem[6]), 32'h1FFF);

    // R9: reset in mid-instruction
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 pc again", 32'(pc_o), 32'h0);
    chk("R9 acc again", 32'(acc_o), 32'h0);
    chk("R9 ie again", 32'(ie_o), 32'h0);
    chk("R9 sp again", 32'(sp_o), 32'h7FF);
    chk("R9 strobes again", 32'({mem_rd, mem_wr}), 32'h0);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule